// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects eleven single-bit interrupt requests from peripherals, external pins and a power-down detector. It decides which one the processor core should service next and presents that choice as a registered request flag and a 16-bit handler address. Each source first passes through a two-flop synchronizer. Depending on the source and its configuration, it is then either latched on a rising edge or followed as a live level. The survivors are gated by a mask, by a global enable, by a one-cycle block after every mask write, and by the nesting rule. The lowest-numbered survivor wins.

The core takes a request by pulsing `irq_ack`. The controller then marks that priority level as in service, clears its edge latch and drops the request. The core pulses `irq_rti` on return from the handler, which retires the highest-priority level still in service. In nesting mode only a strictly more urgent source can preempt a running handler. In sequential mode nothing is granted while any handler is in service. Software sets or clears pending latches through a write-only force/clear port. The core reports mask writes, control writes and global enable/disable through strobes. While reset is asserted the block drives the reset handler address 0x0000 with no request.

Top module: `prio_vec_intc`

## Requirements
- R1: Source index is priority, 0 being most urgent. Vectors are: source 0 (power-down) 0x002C, and source i (1..10) i*4, i.e. 0x0004 up to 0x0028. When requests compete, the lowest index wins.
- R2: A source i in 1..10 is eligible only when mask bit i is 1. Mask bit 0 has no effect, so the power-down source ignores the mask. The mask is cleared by reset.
- R3: Control bits [0], [1] and [2] select edge (1) or level (0) sensing for sources 1, 8 and 9. Sources 2 and 3 are always level-sensed. All other sources are always edge-sensed. Control resets to 0.
- R4: An edge-sensed source stays pending after its input falls, until it is acknowledged or cleared. A level-sensed source is pending only while its synchronized input is high.
- R5: When `fc_we` is high, `fc_set` bits set pending latches and `fc_clr` bits clear them. Clear wins when both are given for the same bit.
- R6: In the second cycle after a mask write is strobed, `irq_req` is low. It returns the cycle after if a request is still eligible.
- R7: `gint_dis` blocks every request, power-down included, regardless of the mask. `gint_en` re-enables, `gint_dis` wins if both are pulsed, and the controller comes out of reset enabled.
- R8: With control bit [3] = 1 (nesting), only sources with an index strictly lower than the lowest index in service are granted. With bit [3] = 0, nothing is granted while any level is in service. `irq_rti` retires the lowest-indexed in-service level.
- R9: `irq_ack` during a request marks that source in service, clears its latch, and forces `irq_req` low in the following cycle.
- R10: Under reset `irq_req` is 0 and `irq_vec` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 11 | Raw interrupt request per source, bit index = priority |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 11 | New mask value, bit i enables source i |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 4 | [2:0] edge select for sources 1, 8, 9; [3] nesting enable |
| fc_we | input | 1 | Force/clear write strobe |
| fc_set | input | 11 | Latches to set |
| fc_clr | input | 11 | Latches to clear |
| gint_en | input | 1 | Global enable strobe |
| gint_dis | input | 1 | Global disable strobe |
| irq_ack | input | 1 | Core takes the presented request |
| irq_rti | input | 1 | Core returns from a handler |
| irq_req | output | 1 | Registered request to the core |
| irq_vec | output | 16 | Handler address of the presented request, 0 when idle |

## Verification
Random trials raise a random subset of sources, then drop a random part of them under random mask and sense settings. The expected winner is recomputed from those settings. A dropped source that is still granted can only be edge-latched, and a dropped source that is lost can only be level-sensed, so these trials separate R3 and R4 as well as checking priority and masking. Directed cases cover the rest. They raise power-down under an all-zero mask, toggle the global gate, and force and clear the software latch. They sample request timing cycle by cycle around a mask write and an acknowledge. They also run a preemption scenario that then switches to sequential mode, so that the two nesting rules and the retire order yield different grants.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int SRC_PWD   = 0;
  localparam int SRC_XA    = 1;
  localparam int SRC_LA    = 2;
  localparam int SRC_LB    = 3;
  localparam int SRC_SWE   = 6;
  localparam int SRC_XB    = 8;
  localparam int SRC_XC    = 9;
  localparam int CTL_SENSE_A = 0;
  localparam int CTL_SENSE_B = 1;
  localparam int CTL_SENSE_C = 2;
  localparam int CTL_NEST    = 3;
endpackage

// File: rtl/pvic_sync_edge.sv
module pvic_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign lvl  = sh[STAGES-1];
  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/pvic_pick.sv
module pvic_pick #(
  parameter int N  = 11,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = IW'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pvic_svc.sv
module pvic_svc #(
  parameter int N  = 11,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          rti,
  output logic [N-1:0]  ins,
  output logic [IW-1:0] top_idx,
  output logic          busy
);
  logic          top_any;
  logic [N-1:0]  low_bit;
  logic [N-1:0]  set_bit;

  pvic_pick #(.N(N), .IW(IW)) u_top (
    .req (ins),
    .any (top_any),
    .idx (top_idx)
  );

  always_comb begin
    low_bit = '0;
    if (top_any) low_bit = N'(1) << top_idx;
    set_bit = set_en ? (N'(1) << set_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) ins <= '0;
    else     ins <= (ins & ~(rti ? low_bit : '0)) | set_bit;
  end

  assign busy = top_any;
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int          NSRC        = 11,
  parameter int          VEC_W       = 16,
  parameter int          VEC_STEP    = 4,
  parameter logic [15:0] PWD_VEC     = 16'h002C,
  parameter int          SYNC_STAGES = 2,
  parameter int          CTL_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_req,
  input  logic             mask_we,
  input  logic [NSRC-1:0]  mask_wdata,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             fc_we,
  input  logic [NSRC-1:0]  fc_set,
  input  logic [NSRC-1:0]  fc_clr,
  input  logic             gint_en,
  input  logic             gint_dis,
  input  logic             irq_ack,
  input  logic             irq_rti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  import pvic_pkg::*;

  localparam int IW = $clog2(NSRC + 1);
  localparam logic [NSRC-1:0] LEVEL_FIXED = (NSRC'(1) << SRC_LA) | (NSRC'(1) << SRC_LB);

  logic [NSRC-1:0]  lvl, rise, latch_q, pending, edge_mode, allow, cand;
  logic [NSRC-1:0]  mask_q, mask_d1, ins;
  logic [CTL_W-1:0] ctl_q;
  logic             gen_q, blk_q, any, busy, take;
  logic [IW-1:0]    idx, idx_q, top_idx;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    pvic_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (src_req[g]),
      .lvl  (lvl[g]),
      .rise (rise[g])
    );
  end

  always_comb begin
    edge_mode              = ~LEVEL_FIXED;
    edge_mode[SRC_XA]      = ctl_q[CTL_SENSE_A];
    edge_mode[SRC_XB]      = ctl_q[CTL_SENSE_B];
    edge_mode[SRC_XC]      = ctl_q[CTL_SENSE_C];
    pending                = latch_q | (~edge_mode & lvl);
  end

  assign take = irq_ack & irq_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if ((fc_we && fc_clr[i]) || (take && idx_q == IW'(i)))
          latch_q[i] <= 1'b0;
        else if ((edge_mode[i] && rise[i]) || (fc_we && fc_set[i]))
          latch_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      mask_d1 <= '0;
      ctl_q   <= '0;
      gen_q   <= 1'b1;
      blk_q   <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      mask_d1 <= mask_q;
      if (ctl_we) ctl_q <= ctl_wdata;
      if (gint_dis)     gen_q <= 1'b0;
      else if (gint_en) gen_q <= 1'b1;
      blk_q <= mask_we;
    end
  end

  pvic_svc #(.N(NSRC), .IW(IW)) u_svc (
    .clk     (clk),
    .rst     (rst),
    .set_en  (take),
    .set_idx (idx_q),
    .rti     (irq_rti),
    .ins     (ins),
    .top_idx (top_idx),
    .busy    (busy)
  );

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      allow[i] = ctl_q[CTL_NEST] ? (IW'(i) < top_idx) : ~busy;
    cand = pending & (mask_q | NSRC'(1)) & allow & {NSRC{gen_q & ~blk_q}};
  end

  pvic_pick #(.N(NSRC), .IW(IW)) u_pick (
    .req (cand),
    .any (any),
    .idx (idx)
  );

  function automatic logic [VEC_W-1:0] vec_of(input logic [IW-1:0] k);
    if (k == '0) return VEC_W'(PWD_VEC);
    return VEC_W'(32'(k) * VEC_STEP);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      idx_q   <= '0;
    end else begin
      irq_req <= any & ~irq_ack;
      irq_vec <= (any & ~irq_ack) ? vec_of(idx) : '0;
      idx_q   <= idx;
    end
  end

  // R7
  gen_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(gen_q));

  // R6
  mask_block_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mask_we, 2) |-> !irq_req);

  // R8
  seq_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !$past(ctl_q[CTL_NEST])) |-> ($past(ins) == '0));

  // R2
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req && idx_q != '0) |-> (|(mask_d1 & (NSRC'(1) << idx_q))));

  // R1
  vec_legal_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec == VEC_W'(PWD_VEC) ||
                 (irq_vec != '0 && (32'(irq_vec) % VEC_STEP) == 0)));

  // R9
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_req) |=> !irq_req);
endmodule

// File: tb/prio_vec_intc_bench.sv
module prio_vec_intc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  src_req = '0;
  logic          mask_we = 1'b0;
  logic [N-1:0]  mask_wdata = '0;
  logic          ctl_we = 1'b0;
  logic [3:0]    ctl_wdata = '0;
  logic          fc_we = 1'b0;
  logic [N-1:0]  fc_set = '0;
  logic [N-1:0]  fc_clr = '0;
  logic          gint_en = 1'b0;
  logic          gint_dis = 1'b0;
  logic          irq_ack = 1'b0;
  logic          irq_rti = 1'b0;
  logic          irq_req;
  logic [15:0]   irq_vec;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_vec_intc u_prio_vec_intc (
    .clk(clk), .rst(rst), .src_req(src_req),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .fc_we(fc_we), .fc_set(fc_set), .fc_clr(fc_clr),
    .gint_en(gint_en), .gint_dis(gint_dis),
    .irq_ack(irq_ack), .irq_rti(irq_rti),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  function automatic logic [15:0] exp_vec(input int i);
    return (i == 0) ? 16'h002C : 16'(i * 4);
  endfunction

  function automatic int lowest(input logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mask(input logic [N-1:0] m);
    mask_wdata = m; mask_we = 1'b1; cyc(1); mask_we = 1'b0;
  endtask

  task automatic wr_ctl(input logic [3:0] c);
    ctl_wdata = c; ctl_we = 1'b1; cyc(1); ctl_we = 1'b0;
  endtask

  task automatic wr_fc(input logic [N-1:0] s, input logic [N-1:0] c);
    fc_set = s; fc_clr = c; fc_we = 1'b1; cyc(1);
    fc_we = 1'b0; fc_set = '0; fc_clr = '0;
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
  endtask

  task automatic pulse_rti();
    irq_rti = 1'b1; cyc(1); irq_rti = 1'b0;
  endtask

  task automatic clean();
    src_req = '0; cyc(5); wr_fc('0, '1); cyc(3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] raise, drop, msk, pend, edge_m, eff;
    logic [3:0]   c;
    int w;
    void'($urandom(32'd1234));

    // R10 reset state
    cyc(3);
    chk("R10 req in reset", 32'(irq_req), 32'd0);
    chk("R10 vec in reset", 32'(irq_vec), 32'h0000);
    rst = 1'b0;
    cyc(2);

    // R1 R2 R3 R4 random trials
    for (int t = 0; t < 40; t++) begin
      clean();
      msk = N'($urandom);
      c   = {1'b0, 3'($urandom)};
      wr_ctl(c);
      wr_mask(msk);
      cyc(3);
      raise = N'($urandom);
      drop  = N'($urandom);
      src_req = raise; cyc(8);
      src_req = raise & ~drop; cyc(8);
      edge_m = ~((N'(1) << 2) | (N'(1) << 3));
      edge_m[1] = c[0]; edge_m[8] = c[1]; edge_m[9] = c[2];
      pend = (raise & ~drop) | (raise & drop & edge_m);
      eff  = pend & (msk | N'(1));
      w = lowest(eff);
      chk("R1 R2 R3 R4 random req", 32'(irq_req), 32'(w >= 0));
      chk("R1 R2 R3 R4 random vec", 32'(irq_vec), (w >= 0) ? 32'(exp_vec(w)) : 32'd0);
    end

    // R2 power-down ignores an all-zero mask
    clean(); wr_ctl(4'b0000); wr_mask('0); cyc(3);
    src_req[0] = 1'b1; cyc(8);
    chk("R2 pwd unmaskable req", 32'(irq_req), 32'd1);
    chk("R1 pwd vector", 32'(irq_vec), 32'h002C);

    // R7 global gate
    gint_dis = 1'b1; cyc(1); gint_dis = 1'b0; cyc(3);
    chk("R7 disabled blocks pwd", 32'(irq_req), 32'd0);
    gint_en = 1'b1; gint_dis = 1'b1; cyc(1); gint_en = 1'b0; gint_dis = 1'b0; cyc(3);
    chk("R7 disable wins", 32'(irq_req), 32'd0);
    gint_en = 1'b1; cyc(1); gint_en = 1'b0; cyc(3);
    chk("R7 re-enabled", 32'(irq_vec), 32'h002C);
    clean();

    // R5 force and clear
    wr_mask('1); cyc(3);
    wr_fc(N'(1) << 6, '0); cyc(4);
    chk("R5 forced vec", 32'(irq_vec), 32'h0018);
    wr_fc('0, N'(1) << 6); cyc(4);
    chk("R5 cleared", 32'(irq_req), 32'd0);
    wr_fc(N'(1) << 6, N'(1) << 6); cyc(4);
    chk("R5 clear wins", 32'(irq_req), 32'd0);

    // R6 block after mask write
    src_req[2] = 1'b1; cyc(8);
    chk("R6 pre vec", 32'(irq_vec), 32'h0008);
    wr_mask('1);
    chk("R6 first cycle still up", 32'(irq_req), 32'd1);
    cyc(1);
    chk("R6 blocked cycle", 32'(irq_req), 32'd0);
    cyc(1);
    chk("R6 resumes", 32'(irq_req), 32'd1);
    clean();

    // R9 R4 ack clears the edge latch
    src_req[6] = 1'b1; cyc(8);
    chk("R4 edge source vec", 32'(irq_vec), 32'h0018);
    pulse_ack();
    chk("R9 req drops after ack", 32'(irq_req), 32'd0);
    pulse_rti(); cyc(4);
    chk("R9 latch cleared by ack", 32'(irq_req), 32'd0);
    clean();

    // R8 nesting then sequential
    wr_ctl(4'b1000); cyc(2);
    src_req[10] = 1'b1; cyc(8);
    chk("R8 timer vec", 32'(irq_vec), 32'h0028);
    pulse_ack(); cyc(4);
    chk("R8 timer in service", 32'(irq_req), 32'd0);
    src_req[4] = 1'b1; cyc(8);
    chk("R8 preempt req", 32'(irq_req), 32'd1);
    chk("R8 preempt vec", 32'(irq_vec), 32'h0010);
    wr_ctl(4'b0000); cyc(3);
    chk("R8 sequential blocks", 32'(irq_req), 32'd0);
    pulse_rti(); cyc(3);
    chk("R8 rti releases", 32'(irq_vec), 32'h0010);
    pulse_ack(); pulse_rti(); clean();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule